// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is a single inter-thread synchronisation cell that holds a saturating counter and arbitrates access to it from several requesters. Each request carries a view code that selects how the counter is reached: a raw view that reads the count directly, a tag view that exposes a small flag word, a pair of empty/full views that do nothing on a semaphore cell, and a pair of P/V views that take and give the semaphore in a waiting or a non-waiting flavour.

A requester that takes the semaphore while the count is zero in the waiting flavour gets a stall answer. Its ID is recorded in a wait set. The next give raises a one-cycle wake pulse on every recorded requester and empties the wait set. The requesters then retry. The cell answers every accepted request one clock later.

Top module: `sema_cell`

## Requirements
- R1: A P/V read (view code 4 or 5) returns the count as it was before the access, and lowers the count by one when it was nonzero.
- R2: A waiting P/V read (view code 4) with the count at zero answers with rsp_stall high and rsp_rdata zero. It leaves the count unchanged and sets bit req_id of the wait set.
- R3: A non-waiting P/V read (view code 5) with the count at zero answers with rdata zero and no stall. It leaves the count and the wait set unchanged.
- R4: A P/V write (view code 4 or 5) ignores req_wdata and raises the count by one. The count saturates at 2**CNT_W-1.
- R5: Every P/V write drives wake_mask, for exactly the cycle after it is accepted, with the wait set as it was before the write, and then empties the wait set. At all other times wake_mask is zero.
- R6: A raw read (view code 0) returns the count zero-extended. A raw write has no effect.
- R7: An empty/full access (view code 2 or 3) has no effect, and a read in these views returns zero.
- R8: A tag read (view code 1) returns a word with E at bit 0, F at bit 1 and T at bit 16; every other bit, including the FIFO flag at bit 17, is zero. A tag write loads T, E and F from those same bit positions of req_wdata and leaves the count unchanged.
- R9: A read with a view code from 6 to 15 returns all ones. A write with such a code has no effect.
- R10: After reset the count is zero, T, E and F are zero, the wait set is empty, and rsp_valid, rsp_stall and wake_mask are low.
- R11: rsp_valid is high for exactly the cycle after each accepted request, and the response fields belong to that request. A write answers with rdata zero and no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_view | input | 4 | View code selecting the access behaviour |
| req_id | input | ID_W | ID of the requester |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | The answer to last cycle's request is present |
| rsp_stall | output | 1 | The requester must wait for a wake pulse |
| rsp_rdata | output | DATA_W | Read data |
| wake_mask | output | REQ_N | One-cycle wake pulse, one bit per requester |

## Verification
The bench builds the cell with CNT_W = 4, REQ_N = 4 and DATA_W = 32. The narrow counter lets a short run of gives reach the saturation value of 15 and test the ceiling. Four requesters are enough to park two different IDs at once and check that a single give wakes both bits together. Thirty-two data bits cover every tag flag position.

// File: rtl/sema_pkg.sv
package sema_pkg;

  localparam int VIEW_W = 4;

  localparam logic [VIEW_W-1:0] VW_RAW     = 4'd0;
  localparam logic [VIEW_W-1:0] VW_TAG     = 4'd1;
  localparam logic [VIEW_W-1:0] VW_EF_WAIT = 4'd2;
  localparam logic [VIEW_W-1:0] VW_EF_TRY  = 4'd3;
  localparam logic [VIEW_W-1:0] VW_PV_WAIT = 4'd4;
  localparam logic [VIEW_W-1:0] VW_PV_TRY  = 4'd5;

  localparam int TAG_E_BIT    = 0;
  localparam int TAG_F_BIT    = 1;
  localparam int TAG_T_BIT    = 16;
  localparam int TAG_FIFO_BIT = 17;
  localparam int TAG_MIN_W    = 18;

  typedef struct packed {
    logic t;
    logic f;
    logic e;
  } tag_flags_t;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_COUNT,
    RD_TAG,
    RD_PV,
    RD_ONES
  } rd_sel_e;

endpackage

// File: rtl/sema_decode.sv
module sema_decode
  import sema_pkg::*;
(
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [VIEW_W-1:0] req_view,
  output logic              ev_pv_take,
  output logic              ev_pv_wait,
  output logic              ev_pv_give,
  output logic              ev_tag_wr,
  output rd_sel_e           rd_sel
);

  logic is_pv;
  logic is_rd;

  assign is_pv = (req_view == VW_PV_WAIT) || (req_view == VW_PV_TRY);
  assign is_rd = req_valid && !req_write;

  assign ev_pv_take = is_rd && is_pv;
  assign ev_pv_wait = is_rd && (req_view == VW_PV_WAIT);
  assign ev_pv_give = req_valid && req_write && is_pv;
  assign ev_tag_wr  = req_valid && req_write && (req_view == VW_TAG);

  always_comb begin
    rd_sel = RD_ZERO;
    if (is_rd) begin
      unique case (req_view)
        VW_RAW:                rd_sel = RD_COUNT;
        VW_TAG:                rd_sel = RD_TAG;
        VW_EF_WAIT, VW_EF_TRY: rd_sel = RD_ZERO;
        VW_PV_WAIT, VW_PV_TRY: rd_sel = RD_PV;
        default:               rd_sel = RD_ONES;
      endcase
    end
  end

endmodule

// File: rtl/sema_counter.sv
module sema_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             give,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_zero
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_up(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] floor_down(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (give)      cnt_d = sat_up(cnt_q);
    else if (take) cnt_d = floor_down(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt      = cnt_q;
  assign cnt_zero = (cnt_q == '0);

  // R1: a take on a nonzero count lowers it by exactly one
  assert_take_dec_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !give && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R2/R3: a take on zero leaves the count at zero
  assert_take_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !give && cnt_q == '0) |=> (cnt_q == '0));

  // R4: a give at the ceiling holds the ceiling
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (give && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R6/R7/R9: without a take or a give the count does not move
  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !give) |=> $stable(cnt_q));

endmodule

// File: rtl/sema_waitset.sv
module sema_waitset #(
  parameter int REQ_N = 8,
  parameter int ID_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             park,
  input  logic [ID_W-1:0]  park_id,
  input  logic             release_all,
  output logic [REQ_N-1:0] wait_set,
  output logic [REQ_N-1:0] wake_mask
);

  logic [REQ_N-1:0] wait_q;
  logic [REQ_N-1:0] wake_q;
  logic [REQ_N-1:0] park_bits;

  for (genvar g = 0; g < REQ_N; g++) begin : g_park
    assign park_bits[g] = park && (park_id == ID_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      wake_q <= '0;
    end else if (release_all) begin
      wake_q <= wait_q;
      wait_q <= '0;
    end else begin
      wake_q <= '0;
      wait_q <= wait_q | park_bits;
    end
  end

  assign wait_set  = wait_q;
  assign wake_mask = wake_q;

  // R5: a release empties the wait set on the next cycle
  assert_release_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    release_all |=> (wait_q == '0));

  // R5: the wake pulse carries the set that was waiting
  assert_wake_payload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    release_all |=> (wake_q == $past(wait_q)));

  // R5: no wake without a release one cycle before
  assert_wake_only_on_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !release_all |=> (wake_q == '0));

  // R2: a parked requester appears in the wait set
  assert_park_recorded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (park && !release_all) |=> ((wait_q & $past(park_bits)) == $past(park_bits)));

endmodule

// File: rtl/sema_tag.sv
module sema_tag
  import sema_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_wr,
  input  logic [DATA_W-1:0] wdata,
  output tag_flags_t        flags
);

  tag_flags_t flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (tag_wr) begin
      flags_q.t <= wdata[TAG_T_BIT];
      flags_q.f <= wdata[TAG_F_BIT];
      flags_q.e <= wdata[TAG_E_BIT];
    end
  end

  assign flags = flags_q;

  // R8: flags move only on a tag write
  assert_tag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_wr |=> $stable(flags_q));

endmodule

// File: rtl/sema_cell.sv
module sema_cell
  import sema_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int REQ_N  = 8,
  parameter int DATA_W = 32,
  localparam int ID_W  = (REQ_N > 1) ? $clog2(REQ_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [3:0]        req_view,
  input  logic [ID_W-1:0]   req_id,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_stall,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [REQ_N-1:0]  wake_mask
);

  logic             ev_pv_take;
  logic             ev_pv_wait;
  logic             ev_pv_give;
  logic             ev_tag_wr;
  logic             ev_block;
  rd_sel_e          rd_sel;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;
  logic [REQ_N-1:0] wait_set;
  tag_flags_t       flags;

  logic [DATA_W-1:0] cnt_word;
  logic [DATA_W-1:0] tag_word;
  logic [DATA_W-1:0] rd_word;

  logic              rsp_valid_q;
  logic              rsp_stall_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  sema_decode u_decode (
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_view   (req_view),
    .ev_pv_take (ev_pv_take),
    .ev_pv_wait (ev_pv_wait),
    .ev_pv_give (ev_pv_give),
    .ev_tag_wr  (ev_tag_wr),
    .rd_sel     (rd_sel)
  );

  assign ev_block = ev_pv_wait && cnt_zero;

  sema_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (ev_pv_take),
    .give     (ev_pv_give),
    .cnt      (cnt),
    .cnt_zero (cnt_zero)
  );

  sema_waitset #(.REQ_N(REQ_N), .ID_W(ID_W)) u_waitset (
    .clk         (clk),
    .rst_n       (rst_n),
    .park        (ev_block),
    .park_id     (req_id),
    .release_all (ev_pv_give),
    .wait_set    (wait_set),
    .wake_mask   (wake_mask)
  );

  sema_tag #(.DATA_W(DATA_W)) u_tag (
    .clk    (clk),
    .rst_n  (rst_n),
    .tag_wr (ev_tag_wr),
    .wdata  (req_wdata),
    .flags  (flags)
  );

  always_comb begin
    cnt_word = '0;
    cnt_word[CNT_W-1:0] = cnt;
  end

  always_comb begin
    tag_word = '0;
    tag_word[TAG_E_BIT]    = flags.e;
    tag_word[TAG_F_BIT]    = flags.f;
    tag_word[TAG_T_BIT]    = flags.t;
    tag_word[TAG_FIFO_BIT] = 1'b0;
  end

  always_comb begin
    unique case (rd_sel)
      RD_COUNT: rd_word = cnt_word;
      RD_TAG:   rd_word = tag_word;
      RD_PV:    rd_word = ev_block ? '0 : cnt_word;
      RD_ONES:  rd_word = '1;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_stall_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid;
      rsp_stall_q <= ev_block;
      rsp_rdata_q <= req_valid ? rd_word : '0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_stall = rsp_stall_q;
  assign rsp_rdata = rsp_rdata_q;

  // R11: every request is answered in the next cycle
  assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R11: a stall is only given to a request
  assert_stall_needs_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_stall |-> rsp_valid);

  // R2: a waiting take on zero answers with a stall and zero data
  assert_block_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pv_wait && cnt == '0) |=> (rsp_stall && rsp_rdata == '0));

  // R1: a take that succeeds answers with the count it found
  assert_take_returns_old_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pv_take && cnt != '0) |=>
      (!rsp_stall && rsp_rdata[CNT_W-1:0] == $past(cnt)));

  // R8: the FIFO flag of a semaphore cell always reads zero
  assert_fifo_flag_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_view == VW_TAG) |=> !rsp_rdata[TAG_FIFO_BIT]);

  initial begin
    assert (DATA_W >= TAG_MIN_W && DATA_W >= CNT_W)
      else $error("sema_cell: DATA_W too narrow");
  end

endmodule

// File: tb/test_sema_cell.sv
module test_sema_cell;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 4;
  localparam int REQ_N  = 4;
  localparam int DATA_W = 32;
  localparam int ID_W   = 2;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_write;
  logic [3:0]        req_view;
  logic [ID_W-1:0]   req_id;
  logic [DATA_W-1:0] req_wdata;
  logic              rsp_valid;
  logic              rsp_stall;
  logic [DATA_W-1:0] rsp_rdata;
  logic [REQ_N-1:0]  wake_mask;

  int checks;
  int failures;
  int exp_cnt;

  logic              got_valid;
  logic              got_stall;
  logic [DATA_W-1:0] got_rdata;
  logic [REQ_N-1:0]  got_wake;

  sema_cell #(.CNT_W(CNT_W), .REQ_N(REQ_N), .DATA_W(DATA_W)) i_sema_cell (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_view  (req_view),
    .req_id    (req_id),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_stall (rsp_stall),
    .rsp_rdata (rsp_rdata),
    .wake_mask (wake_mask)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at the falling edge, sample at the following falling edge
  task automatic access(input logic wr, input logic [3:0] view,
                        input logic [ID_W-1:0] id, input logic [DATA_W-1:0] wd);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_view  = view;
    req_id    = id;
    req_wdata = wd;
    @(negedge clk);
    got_valid = rsp_valid;
    got_stall = rsp_stall;
    got_rdata = rsp_rdata;
    got_wake  = wake_mask;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_wdata = '0;
  endtask

  task automatic give_pv(input logic [3:0] view, input logic [DATA_W-1:0] wd,
                         input logic [REQ_N-1:0] exp_wake, input string tag);
    access(1'b1, view, '0, wd);
    if (exp_cnt < CNT_MAX) exp_cnt++;
    chk({tag, " wake"}, 32'(got_wake), 32'(exp_wake));
    chk({tag, " wrdata"}, got_rdata, 32'h0);
  endtask

  task automatic peek_count(input string tag);
    access(1'b0, 4'd0, '0, '0);
    chk(tag, got_rdata, 32'(exp_cnt));
  endtask

  task automatic t_reset;
    chk("R10 rsp_valid", 32'(rsp_valid), 32'h0);
    chk("R10 rsp_stall", 32'(rsp_stall), 32'h0);
    chk("R10 wake", 32'(wake_mask), 32'h0);
    peek_count("R10 count");
    chk("R11 valid after req", 32'(got_valid), 32'h1);
    access(1'b0, 4'd1, '0, '0);
    chk("R10 tag word", got_rdata, 32'h0);
    @(negedge clk);
    chk("R11 valid drops", 32'(rsp_valid), 32'h0);
  endtask

  task automatic t_pv_basic;
    give_pv(4'd4, 32'hDEAD_BEEF, 4'h0, "R4 give1");
    give_pv(4'd5, 32'h0, 4'h0, "R4 give2");
    give_pv(4'd4, 32'h1234, 4'h0, "R4 give3");
    peek_count("R4 count 3");
    access(1'b0, 4'd4, 2'd0, '0);
    chk("R1 wait take old", got_rdata, 32'(exp_cnt));
    chk("R1 no stall", 32'(got_stall), 32'h0);
    exp_cnt--;
    peek_count("R1 count 2");
    access(1'b0, 4'd5, 2'd2, '0);
    chk("R1 try take old", got_rdata, 32'(exp_cnt));
    exp_cnt--;
    peek_count("R6 count 1");
  endtask

  task automatic t_block;
    access(1'b0, 4'd4, 2'd0, '0);
    chk("R1 take last", got_rdata, 32'h1);
    exp_cnt--;
    access(1'b0, 4'd4, 2'd1, '0);
    chk("R2 stall id1", 32'(got_stall), 32'h1);
    chk("R2 rdata zero", got_rdata, 32'h0);
    access(1'b0, 4'd4, 2'd3, '0);
    chk("R2 stall id3", 32'(got_stall), 32'h1);
    access(1'b0, 4'd5, 2'd2, '0);
    chk("R3 try no stall", 32'(got_stall), 32'h0);
    chk("R3 try rdata", got_rdata, 32'h0);
    peek_count("R2 count held 0");
    give_pv(4'd5, 32'hFFFF_FFFF, 4'b1010, "R5 wake ids 1,3");
    chk("R3 id2 not parked", 32'(got_wake[2]), 32'h0);
    @(negedge clk);
    chk("R5 pulse one cycle", 32'(wake_mask), 32'h0);
    give_pv(4'd4, 32'h0, 4'h0, "R5 set emptied");
    peek_count("R4 count after wakes");
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 20; i++) give_pv(4'd4, 32'(i), 4'h0, "R4 sat give");
    peek_count("R4 saturated");
    chk("R4 ceiling", 32'(exp_cnt), 32'(CNT_MAX));
    access(1'b0, 4'd5, 2'd1, '0);
    chk("R1 take at max", got_rdata, 32'(CNT_MAX));
    exp_cnt--;
  endtask

  task automatic t_no_effect;
    access(1'b1, 4'd0, 2'd0, 32'h7);
    peek_count("R6 raw write ignored");
    access(1'b1, 4'd2, 2'd1, 32'h55);
    access(1'b1, 4'd3, 2'd1, 32'h55);
    peek_count("R7 ef writes ignored");
    access(1'b0, 4'd2, 2'd1, '0);
    chk("R7 ef wait read", got_rdata, 32'h0);
    chk("R7 ef no stall", 32'(got_stall), 32'h0);
    access(1'b0, 4'd3, 2'd1, '0);
    chk("R7 ef try read", got_rdata, 32'h0);
    peek_count("R7 count unchanged");
    access(1'b0, 4'd9, 2'd0, '0);
    chk("R9 bad view read", got_rdata, 32'hFFFF_FFFF);
    access(1'b1, 4'd6, 2'd0, 32'h1_0003);
    access(1'b1, 4'd15, 2'd0, 32'h1_0003);
    peek_count("R9 bad view write ignored");
    access(1'b0, 4'd1, 2'd0, '0);
    chk("R9 tag untouched", got_rdata, 32'h0);
  endtask

  task automatic t_tag;
    access(1'b1, 4'd1, 2'd0, 32'hFFFF_FFFF);
    access(1'b0, 4'd1, 2'd0, '0);
    chk("R8 all flags", got_rdata, 32'h0001_0003);
    access(1'b1, 4'd1, 2'd0, 32'hFFFE_FFFC);
    access(1'b0, 4'd1, 2'd0, '0);
    chk("R8 other bits ignored", got_rdata, 32'h0);
    access(1'b1, 4'd1, 2'd0, 32'h0000_0002);
    access(1'b0, 4'd1, 2'd0, '0);
    chk("R8 F only", got_rdata, 32'h0000_0002);
    peek_count("R8 count untouched");
  endtask

  initial begin
    checks = 0;
    failures = 0;
    exp_cnt = 0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_view = '0;
    req_id = '0;
    req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pv_basic();
    t_block();
    t_saturate();
    t_no_effect();
    t_tag();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule